// File: doc/BRIEF.md
# Data-Side Protected Translation Lookup

This block is a small, fully associative translation table for data accesses. Each slot maps a virtual page to a physical page. It holds an address-space tag, a page-size selector (4 KiB or 16 KiB), a shared flag, a valid flag, a cache-inhibit flag, a two-bit access-rights code and a four-bit qualifier field. A lookup request carries an effective address, the current address-space tag, a privileged/problem flag and a read/write flag. One cycle later the block reports hit, the physical address, the cache-inhibit attribute and whether the access breaks the page's access rights.

A global mode input sets how each slot's four-bit field is read. With the mode at 0, the field holds one valid bit for each 1 KiB quarter of a 4 KiB page. With the mode at 1, the field says which privilege levels the slot may hit for. Maintenance is done through three ports: a single-cycle slot write at an index, an invalidation of every slot that covers a given page, and a whole-table invalidation. Table walking and miss recovery belong to the surrounding logic.

Top module: `dtlb_guard`

## Requirements
- R1: After reset every slot is invalid, so any lookup misses. All response outputs are 0 while in reset and in every cycle that follows a cycle with no request. A request sampled at one clock edge is answered on the outputs after that edge, with rsp_valid at 1.
- R2: With wr_en at 1, the slot at wr_idx takes all wr_* fields at the clock edge. Lookups from the next cycle on see the new contents.
- R3: A 4 KiB slot (size bit 0) compares its page number with EA[31:12] and forms the physical address as {rpn, EA[11:0]}. A 16 KiB slot (size bit 1) leaves the two low page-number bits out of the compare and forms {rpn[19:2], EA[13:0]}.
- R4: A slot with shared at 0 matches only when its tag equals req_asid. With shared at 1 the tag is not compared.
- R5: A slot with its valid bit at 0 never hits.
- R6: With mode_qual at 0, field bit (3 − EA[11:10]) must be 1 for a hit. Bit 3 is the quarter at EA[11:10]=00 and bit 0 is quarter 11.
- R7: With mode_qual at 1, field bit 3 enables hits for privileged accesses (req_priv=1) and field bit 2 enables hits for problem accesses. So 1000 hits privileged only, 0100 hits problem only and 1100 hits both.
- R8: Rights code 00 denies every access. 01 allows read/write when privileged and denies problem accesses. 10 allows read/write when privileged and reads only in problem mode. 11 allows everything. A denied access sets rsp_viol.
- R9: rsp_viol is 1 only together with rsp_hit. A miss never reports a violation.
- R10: rsp_ci carries the hitting slot's cache-inhibit flag and is 0 on a miss.
- R11: When several slots match, the one with the lowest index supplies the result.
- R12: With inv_page_en at 1, every slot whose page (taking its size into account) covers inv_vpn becomes invalid, whatever its tag.
- R13: With inv_all_en at 1, every slot becomes invalid. Both invalidations win over a write to the same slot in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_qual | input | 1 | Field mode: 0 quarter valid bits, 1 privilege qualifiers |
| req_valid | input | 1 | Lookup request |
| req_ea | input | 32 | Effective address |
| req_asid | input | 4 | Current address-space tag |
| req_priv | input | 1 | 1 privileged, 0 problem |
| req_write | input | 1 | 1 write, 0 read |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 3 | Slot index |
| wr_valid | input | 1 | Valid flag to store |
| wr_epn | input | 20 | Virtual page number |
| wr_rpn | input | 20 | Physical page number |
| wr_asid | input | 4 | Address-space tag |
| wr_big | input | 1 | Page size: 0 4 KiB, 1 16 KiB |
| wr_shared | input | 1 | Skip the tag compare |
| wr_ci | input | 1 | Cache-inhibit flag |
| wr_pp | input | 2 | Access-rights code |
| wr_sub | input | 4 | Quarter-valid / privilege-qualifier field |
| inv_page_en | input | 1 | Invalidate by page |
| inv_vpn | input | 20 | Page number to invalidate |
| inv_all_en | input | 1 | Invalidate every slot |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ra | output | 32 | Physical address, 0 on a miss |
| rsp_ci | output | 1 | Cache-inhibit of the hit |
| rsp_viol | output | 1 | Access-rights violation |

## Verification
The bench builds a 16 KiB slot and probes addresses that differ only in bits 13:12. A design that compared the full page number would miss these, and one that took the wrong offset width would give the wrong physical address. It moves through each quarter under mode 0 and through each privilege under mode 1, because a reversed bit order would hit the wrong quarter or the wrong level. It also checks that a miss on a no-access page reports no violation, that two matching slots resolve to the lower index, that a page invalidation inside a large page clears it while sparing others, and that a whole-table invalidation beats a same-cycle write.

// File: rtl/dtlb_guard_pkg.sv
package dtlb_guard_pkg;

   typedef enum logic [1:0] {
      PP_NONE  = 2'b00,
      PP_SUPV  = 2'b01,
      PP_URO   = 2'b10,
      PP_ALL   = 2'b11
   } pp_code_e;

   localparam int OFS_SMALL = 12;
   localparam int OFS_LARGE = 14;

endpackage

// File: rtl/dtlb_prot_chk.sv
module dtlb_prot_chk
   import dtlb_guard_pkg::*;
(
   input  logic [1:0] pp,
   input  logic       priv,
   input  logic       write,
   output logic       deny
);
   always_comb begin
      unique case (pp_code_e'(pp))
         PP_NONE: deny = 1'b1;
         PP_SUPV: deny = !priv;
         PP_URO:  deny = !priv && write;
         default: deny = 1'b0;
      endcase
   end
endmodule

// File: rtl/dtlb_entry_cmp.sv
module dtlb_entry_cmp #(
   parameter int EPN_W  = 20,
   parameter int ASID_W = 4
) (
   input  logic              ent_valid,
   input  logic [EPN_W-1:0]  ent_epn,
   input  logic [ASID_W-1:0] ent_asid,
   input  logic              ent_big,
   input  logic              ent_shared,
   input  logic [3:0]        ent_sub,
   input  logic              mode_qual,
   input  logic [EPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_priv,
   input  logic [1:0]        lk_qtr,
   input  logic [EPN_W-1:0]  inv_vpn,
   output logic              lk_match,
   output logic              inv_match
);
   logic lk_page, inv_page, tag_ok, sub_ok;

   always_comb begin
      if (ent_big) begin
         lk_page  = (ent_epn[EPN_W-1:2] == lk_vpn[EPN_W-1:2]);
         inv_page = (ent_epn[EPN_W-1:2] == inv_vpn[EPN_W-1:2]);
      end else begin
         lk_page  = (ent_epn == lk_vpn);
         inv_page = (ent_epn == inv_vpn);
      end
      tag_ok = ent_shared || (ent_asid == lk_asid);
      if (mode_qual)
         sub_ok = lk_priv ? ent_sub[3] : ent_sub[2];
      else
         sub_ok = ent_sub[2'd3 - lk_qtr];
      lk_match  = ent_valid && lk_page && tag_ok && sub_ok;
      inv_match = ent_valid && inv_page;
   end
endmodule

// File: rtl/dtlb_guard.sv
module dtlb_guard #(
   parameter int ENTRIES = 8,
   parameter int EA_W    = 32,
   parameter int ASID_W  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_qual,
   input  logic                       req_valid,
   input  logic [EA_W-1:0]            req_ea,
   input  logic [ASID_W-1:0]          req_asid,
   input  logic                       req_priv,
   input  logic                       req_write,
   input  logic                       wr_en,
   input  logic [$clog2(ENTRIES)-1:0] wr_idx,
   input  logic                       wr_valid,
   input  logic [EA_W-13:0]           wr_epn,
   input  logic [EA_W-13:0]           wr_rpn,
   input  logic [ASID_W-1:0]          wr_asid,
   input  logic                       wr_big,
   input  logic                       wr_shared,
   input  logic                       wr_ci,
   input  logic [1:0]                 wr_pp,
   input  logic [3:0]                 wr_sub,
   input  logic                       inv_page_en,
   input  logic [EA_W-13:0]           inv_vpn,
   input  logic                       inv_all_en,
   output logic                       rsp_valid,
   output logic                       rsp_hit,
   output logic [EA_W-1:0]            rsp_ra,
   output logic                       rsp_ci,
   output logic                       rsp_viol
);
   import dtlb_guard_pkg::*;

   localparam int EPN_W = EA_W - OFS_SMALL;
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (EA_W < 16) begin : g_bad_ea
      $error("EA_W must be at least 16");
   end

   logic [ENTRIES-1:0] ent_v, ent_big, ent_sh, ent_ci;
   logic [EPN_W-1:0]   ent_epn [ENTRIES];
   logic [EPN_W-1:0]   ent_rpn [ENTRIES];
   logic [ASID_W-1:0]  ent_asid[ENTRIES];
   logic [1:0]         ent_pp  [ENTRIES];
   logic [3:0]         ent_sub [ENTRIES];
   logic [ENTRIES-1:0] lk_match, inv_match;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      dtlb_entry_cmp #(.EPN_W(EPN_W), .ASID_W(ASID_W)) i_cmp (
         .ent_valid (ent_v[g]),
         .ent_epn   (ent_epn[g]),
         .ent_asid  (ent_asid[g]),
         .ent_big   (ent_big[g]),
         .ent_shared(ent_sh[g]),
         .ent_sub   (ent_sub[g]),
         .mode_qual (mode_qual),
         .lk_vpn    (req_ea[EA_W-1:OFS_SMALL]),
         .lk_asid   (req_asid),
         .lk_priv   (req_priv),
         .lk_qtr    (req_ea[11:10]),
         .inv_vpn   (inv_vpn),
         .lk_match  (lk_match[g]),
         .inv_match (inv_match[g])
      );
   end

   // valid flags: reset, write, then invalidations override
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_v <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (inv_all_en || (inv_page_en && inv_match[i]))
               ent_v[i] <= 1'b0;
            else if (wr_en && wr_idx == IDX_W'(i))
               ent_v[i] <= wr_valid;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         ent_epn[wr_idx]  <= wr_epn;
         ent_rpn[wr_idx]  <= wr_rpn;
         ent_asid[wr_idx] <= wr_asid;
         ent_big[wr_idx]  <= wr_big;
         ent_sh[wr_idx]   <= wr_shared;
         ent_ci[wr_idx]   <= wr_ci;
         ent_pp[wr_idx]   <= wr_pp;
         ent_sub[wr_idx]  <= wr_sub;
      end
   end

   // lowest index wins
   logic [IDX_W-1:0] sel;
   logic             any_hit;
   always_comb begin
      sel = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (lk_match[i]) sel = IDX_W'(i);
      any_hit = |lk_match;
   end

   logic            deny;
   logic [EA_W-1:0] ra_next;

   dtlb_prot_chk i_prot (
      .pp   (ent_pp[sel]),
      .priv (req_priv),
      .write(req_write),
      .deny (deny)
   );

   always_comb begin
      if (ent_big[sel])
         ra_next = {ent_rpn[sel][EPN_W-1:2], req_ea[OFS_LARGE-1:0]};
      else
         ra_next = {ent_rpn[sel], req_ea[OFS_SMALL-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_ra    <= '0;
         rsp_ci    <= 1'b0;
         rsp_viol  <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && any_hit;
         rsp_ra    <= (req_valid && any_hit) ? ra_next : '0;
         rsp_ci    <= req_valid && any_hit && ent_ci[sel];
         rsp_viol  <= req_valid && any_hit && deny;
      end
   end
endmodule

// File: rtl/dtlb_guard_chk.sv
module dtlb_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic inv_all_en,
   input logic rsp_valid,
   input logic rsp_hit,
   input logic rsp_ci,
   input logic rsp_viol
);
   a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == $past(req_valid));

   a_r1_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_hit);

   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(rst_n, 2)) |-> !rsp_hit);

   a_r9_miss_no_viol: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_viol |-> rsp_hit);

   a_r10_ci_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ci |-> rsp_hit);

   a_r13_flush_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(inv_all_en, 2)) |-> !rsp_hit);
endmodule

bind dtlb_guard dtlb_guard_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .inv_all_en(inv_all_en),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_ci    (rsp_ci),
   .rsp_viol  (rsp_viol)
);

// File: tb/test_dtlb_guard.sv
module test_dtlb_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_qual = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_ea = '0;
   logic [3:0]  req_asid = '0;
   logic        req_priv = 1'b0, req_write = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic        wr_valid = 1'b0;
   logic [19:0] wr_epn = '0, wr_rpn = '0;
   logic [3:0]  wr_asid = '0;
   logic        wr_big = 1'b0, wr_shared = 1'b0, wr_ci = 1'b0;
   logic [1:0]  wr_pp = '0;
   logic [3:0]  wr_sub = '0;
   logic        inv_page_en = 1'b0;
   logic [19:0] inv_vpn = '0;
   logic        inv_all_en = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_ci, rsp_viol;
   logic [31:0] rsp_ra;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dtlb_guard i_dtlb_guard (.*);

   task automatic check(string rq, logic [63:0] got, logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", rq, got, exp);
      end
   endtask

   task automatic put(int idx, logic v, logic [19:0] epn, logic [19:0] rpn,
                      logic [3:0] asid, logic big, logic sh, logic ci,
                      logic [1:0] pp, logic [3:0] sub);
      @(negedge clk);
      wr_en = 1; wr_idx = 3'(idx); wr_valid = v; wr_epn = epn; wr_rpn = rpn;
      wr_asid = asid; wr_big = big; wr_shared = sh; wr_ci = ci; wr_pp = pp; wr_sub = sub;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic look(logic [31:0] ea, logic [3:0] asid, logic priv, logic wr);
      @(negedge clk);
      req_valid = 1; req_ea = ea; req_asid = asid; req_priv = priv; req_write = wr;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic t_reset;
      check("R1 idle valid", rsp_valid, 0);
      check("R1 idle hit", rsp_hit, 0);
      look(32'h1234_5678, 4'd3, 1, 0);
      check("R1 response valid", rsp_valid, 1);
      check("R1 empty table miss", rsp_hit, 0);
      check("R1 ra zero on miss", rsp_ra, 0);
      look(32'h0000_0000, 4'd0, 0, 1);
      check("R1 empty table miss 2", rsp_hit, 0);
      @(negedge clk);
      check("R1 no response without request", rsp_valid, 0);
   endtask

   task automatic t_basic;
      put(0, 1, 20'h12345, 20'hABCDE, 4'd3, 0, 0, 1, 2'b11, 4'b1111);
      look(32'h1234_5678, 4'd3, 1, 0);
      check("R2 written slot hit", rsp_hit, 1);
      check("R3 small page ra", rsp_ra, 32'hABCD_E678);
      check("R10 ci on hit", rsp_ci, 1);
      check("R8 full rights no viol", rsp_viol, 0);
      look(32'h1234_5678, 4'd4, 1, 0);
      check("R4 tag mismatch misses", rsp_hit, 0);
      check("R10 ci 0 on miss", rsp_ci, 0);
      look(32'h1234_6678, 4'd3, 1, 0);
      check("R3 neighbour 4K page misses", rsp_hit, 0);
      put(0, 1, 20'h12345, 20'h55555, 4'd3, 0, 0, 0, 2'b11, 4'b1111);
      look(32'h1234_5001, 4'd3, 0, 1);
      check("R2 overwrite new ra", rsp_ra, 32'h5555_5001);
      check("R10 ci cleared", rsp_ci, 0);
      put(5, 0, 20'h00070, 20'h00001, 4'd0, 0, 1, 0, 2'b11, 4'b1111);
      look(32'h0007_0000, 4'd0, 1, 0);
      check("R5 invalid slot misses", rsp_hit, 0);
   endtask

   task automatic t_rights;
      put(1, 1, 20'h00010, 20'h00200, 4'd7, 0, 1, 0, 2'b10, 4'b1111);
      look(32'h0001_0004, 4'd2, 0, 1);
      check("R4 shared skips tag", rsp_hit, 1);
      check("R8 problem write on 10", rsp_viol, 1);
      look(32'h0001_0004, 4'd2, 0, 0);
      check("R8 problem read on 10", rsp_viol, 0);
      look(32'h0001_0004, 4'd2, 1, 1);
      check("R8 priv write on 10", rsp_viol, 0);
      put(3, 1, 20'h00020, 20'h00300, 4'd0, 0, 1, 0, 2'b00, 4'b1111);
      look(32'h0002_0000, 4'd0, 1, 0);
      check("R8 priv read on 00", rsp_viol, 1);
      put(4, 1, 20'h00050, 20'h00400, 4'd5, 0, 0, 0, 2'b00, 4'b1111);
      look(32'h0005_0000, 4'd6, 1, 1);
      check("R9 miss on no-access page hit", rsp_hit, 0);
      check("R9 miss no viol", rsp_viol, 0);
   endtask

   task automatic t_large;
      put(2, 1, 20'h40000, 20'h80007, 4'd0, 1, 1, 0, 2'b01, 4'b1111);
      look(32'h4000_3ABC, 4'd9, 1, 0);
      check("R3 large page hit", rsp_hit, 1);
      check("R3 large page ra", rsp_ra, 32'h8000_7ABC);
      check("R8 priv on 01", rsp_viol, 0);
      look(32'h4000_1000, 4'd9, 0, 0);
      check("R8 problem on 01", rsp_viol, 1);
      look(32'h4000_4ABC, 4'd9, 1, 0);
      check("R3 next 16K page misses", rsp_hit, 0);
   endtask

   task automatic t_quarters;
      put(4, 1, 20'h00030, 20'h00600, 4'd0, 0, 1, 0, 2'b11, 4'b0100);
      mode_qual = 0;
      look(32'h0003_0000, 4'd0, 1, 0);
      check("R6 quarter 0 invalid", rsp_hit, 0);
      look(32'h0003_0400, 4'd0, 1, 0);
      check("R6 quarter 1 valid", rsp_hit, 1);
      look(32'h0003_0C00, 4'd0, 1, 0);
      check("R6 quarter 3 invalid", rsp_hit, 0);
      mode_qual = 1;
      look(32'h0003_0000, 4'd0, 0, 0);
      check("R7 0100 problem hits", rsp_hit, 1);
      look(32'h0003_0000, 4'd0, 1, 0);
      check("R7 0100 priv misses", rsp_hit, 0);
      put(4, 1, 20'h00030, 20'h00600, 4'd0, 0, 1, 0, 2'b11, 4'b1000);
      look(32'h0003_0C00, 4'd0, 1, 0);
      check("R7 1000 priv hits", rsp_hit, 1);
      look(32'h0003_0C00, 4'd0, 0, 0);
      check("R7 1000 problem misses", rsp_hit, 0);
      mode_qual = 0;
   endtask

   task automatic t_priority_inv;
      put(7, 1, 20'h00060, 20'h00222, 4'd0, 0, 1, 1, 2'b11, 4'b1111);
      put(6, 1, 20'h00060, 20'h00111, 4'd0, 0, 1, 0, 2'b11, 4'b1111);
      look(32'h0006_0123, 4'd0, 1, 0);
      check("R11 lowest index ra", rsp_ra, 32'h0011_1123);
      check("R11 lowest index ci", rsp_ci, 0);
      @(negedge clk); inv_page_en = 1; inv_vpn = 20'h00060;
      @(negedge clk); inv_page_en = 0;
      look(32'h0006_0123, 4'd0, 1, 0);
      check("R12 both copies gone", rsp_hit, 0);
      @(negedge clk); inv_page_en = 1; inv_vpn = 20'h40001;
      @(negedge clk); inv_page_en = 0;
      look(32'h4000_3ABC, 4'd0, 1, 0);
      check("R12 large page cleared by inner page", rsp_hit, 0);
      look(32'h1234_5000, 4'd3, 1, 0);
      check("R12 other slot kept", rsp_hit, 1);
      @(negedge clk);
      inv_all_en = 1;
      wr_en = 1; wr_idx = 3'd0; wr_valid = 1; wr_epn = 20'h00099; wr_rpn = 20'h1;
      wr_asid = 0; wr_big = 0; wr_shared = 1; wr_ci = 0; wr_pp = 2'b11; wr_sub = 4'hF;
      @(negedge clk);
      inv_all_en = 0; wr_en = 0;
      look(32'h0009_9000, 4'd0, 1, 0);
      check("R13 flush beats write", rsp_hit, 0);
      look(32'h0001_0004, 4'd2, 1, 0);
      check("R13 shared slot gone", rsp_hit, 0);
      look(32'h0003_0C00, 4'd0, 1, 0);
      check("R13 quarter slot gone", rsp_hit, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_basic();
      t_rights();
      t_large();
      t_quarters();
      t_priority_inv();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule